// File: doc/BRIEF.md
# Shared Video RAM Address Arbiter

This block sits in front of a single-port video RAM that two parties use: the CPU and the display scan counter. The scan counter normally owns the RAM. It presents a 10-bit character-cell address made of a row index and a column index, and the RAM contents it fetches feed the display pipeline. While the display side owns the RAM, the RAM write strobe is held inactive, because the display never writes. The read-buffer enable is also held inactive, so the buffer that drives RAM data onto the CPU data bus stays off.

When the CPU address decoder recognises an access to the video RAM range, it pulls an active-low select low. For as long as the select stays low, the RAM address comes from the low bits of the CPU address bus, and the CPU read and write strobes reach the RAM unchanged. There are no wait states and no arbitration: the CPU simply takes the RAM for those cycles. A snatched flag tells the display path that whatever it fetches during such a cycle is not valid. Every output is a combinational function of the present inputs.

Top module: `vram_share_arb`

## Requirements
- R1: While `vid_sel_n` is 0, `vram_addr` equals `cpu_addr[9:0]`.
- R2: While `vid_sel_n` is 1, `vram_addr` equals `{scan_row, scan_col}`. The 4 row bits occupy bits 9..6 and the 6 column bits occupy bits 5..0, so the address equals row*64 + col.
- R3: While `vid_sel_n` is 1, `vram_we_n` is 1, whatever the value of `cpu_wr_n`.
- R4: While `vid_sel_n` is 1, `vram_rd_n` is 1, whatever the value of `cpu_rd_n`.
- R5: While `vid_sel_n` is 0, `vram_we_n` equals `cpu_wr_n`.
- R6: While `vid_sel_n` is 0, `vram_rd_n` equals `cpu_rd_n`.
- R7: `scan_snatched` is 1 exactly when `vid_sel_n` is 0.
- R8: CPU address bits above bit 9 have no effect on any output.
- R9: Outputs follow a change of the select, the addresses or the strobes within the same clock cycle, with no register stage in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| vid_sel_n | input | 1 | Active-low video RAM select from the CPU address decoder |
| cpu_addr | input | 16 | CPU address bus |
| cpu_wr_n | input | 1 | Active-low CPU write strobe |
| cpu_rd_n | input | 1 | Active-low CPU read strobe |
| scan_row | input | 4 | Character-row index from the scan counter |
| scan_col | input | 6 | Character-column index from the scan counter |
| vram_addr | output | 10 | Address applied to the video RAM |
| vram_we_n | output | 1 | Active-low RAM write strobe |
| vram_rd_n | output | 1 | Active-low enable of the RAM-to-CPU data buffer |
| scan_snatched | output | 1 | 1 when the CPU owns the RAM in this cycle |

## Verification
The display side is driven with corner cells (0,0), (15,63) and mixed row/column values. These show that the row sits above the column and that neither field is shifted or truncated. CPU accesses are applied with read-only, write-only and idle strobe combinations, which separates a correct pass-through from swapped or constant strobes. The CPU strobes are also pulled low while the display side owns the RAM, and the upper CPU address bits are toggled; each of these must leave the outputs unchanged. Vectors that flip the select back and forth between consecutive cycles confirm that the outputs switch in the same cycle.

// File: rtl/vram_share_pkg.sv
package vram_share_pkg;

    // Values driven toward the RAM in one cycle
    typedef struct packed {
        logic [9:0] addr;
        logic       we_n;
        logic       rd_n;
        logic       snatched;
    } ram_side_t;

    typedef enum logic {
        OWNER_CPU  = 1'b0,
        OWNER_SCAN = 1'b1
    } owner_e;

endpackage

// File: rtl/vram_addr_mux.sv
module vram_addr_mux #(
    parameter int CPU_AW = 16,
    parameter int ROW_W  = 4,
    parameter int COL_W  = 6
) (
    input  vram_share_pkg::owner_e     owner,
    input  logic [CPU_AW-1:0]          cpu_addr,
    input  logic [ROW_W-1:0]           scan_row,
    input  logic [COL_W-1:0]           scan_col,
    output logic [ROW_W+COL_W-1:0]     addr_d
);
    localparam int RAM_AW = ROW_W + COL_W;

    logic [RAM_AW-1:0] cpu_part;
    logic [RAM_AW-1:0] scan_part;

    // Only the low RAM_AW CPU bits reach the RAM
    generate
        if (CPU_AW >= RAM_AW) begin : g_trim
            assign cpu_part = cpu_addr[RAM_AW-1:0];
        end else begin : g_pad
            assign cpu_part = {{(RAM_AW-CPU_AW){1'b0}}, cpu_addr};
        end
    endgenerate

    assign scan_part = {scan_row, scan_col};

    always_comb begin
        if (owner == vram_share_pkg::OWNER_CPU)
            addr_d = cpu_part;
        else
            addr_d = scan_part;
    end
endmodule

// File: rtl/vram_strobe_gate.sv
module vram_strobe_gate (
    input  vram_share_pkg::owner_e owner,
    input  logic                   cpu_wr_n,
    input  logic                   cpu_rd_n,
    output logic                   we_n_d,
    output logic                   rd_n_d,
    output logic                   snatched_d
);
    always_comb begin
        // Display side never writes and never drives the CPU bus
        we_n_d     = 1'b1;
        rd_n_d     = 1'b1;
        snatched_d = 1'b0;
        if (owner == vram_share_pkg::OWNER_CPU) begin
            we_n_d     = cpu_wr_n;
            rd_n_d     = cpu_rd_n;
            snatched_d = 1'b1;
        end
    end
endmodule

// File: rtl/vram_share_arb.sv
module vram_share_arb #(
    parameter int CPU_AW = 16,
    parameter int ROW_W  = 4,
    parameter int COL_W  = 6
) (
    input  logic                   vid_sel_n,
    input  logic [CPU_AW-1:0]      cpu_addr,
    input  logic                   cpu_wr_n,
    input  logic                   cpu_rd_n,
    input  logic [ROW_W-1:0]       scan_row,
    input  logic [COL_W-1:0]       scan_col,
    output logic [ROW_W+COL_W-1:0] vram_addr,
    output logic                   vram_we_n,
    output logic                   vram_rd_n,
    output logic                   scan_snatched
);
    import vram_share_pkg::*;

    localparam int RAM_AW = ROW_W + COL_W;

    owner_e            owner_d;
    logic [RAM_AW-1:0] addr_d;
    logic              we_n_d;
    logic              rd_n_d;
    logic              snatched_d;
    ram_side_t         out_d;

    // The select itself names the owner: low means CPU
    assign owner_d = owner_e'(vid_sel_n);

    vram_addr_mux #(
        .CPU_AW (CPU_AW),
        .ROW_W  (ROW_W),
        .COL_W  (COL_W)
    ) u_addr_mux (
        .owner    (owner_d),
        .cpu_addr (cpu_addr),
        .scan_row (scan_row),
        .scan_col (scan_col),
        .addr_d   (addr_d)
    );

    vram_strobe_gate u_strobe_gate (
        .owner      (owner_d),
        .cpu_wr_n   (cpu_wr_n),
        .cpu_rd_n   (cpu_rd_n),
        .we_n_d     (we_n_d),
        .rd_n_d     (rd_n_d),
        .snatched_d (snatched_d)
    );

    // Output bundle; no register stage, outputs follow inputs in-cycle
    always_comb begin
        out_d          = '0;
        out_d.addr     = addr_d;
        out_d.we_n     = we_n_d;
        out_d.rd_n     = rd_n_d;
        out_d.snatched = snatched_d;
    end

    assign vram_addr     = out_d.addr;
    assign vram_we_n     = out_d.we_n;
    assign vram_rd_n     = out_d.rd_n;
    assign scan_snatched = out_d.snatched;
endmodule

// File: rtl/vram_share_chk.sv
module vram_share_chk #(
    parameter int CPU_AW = 16,
    parameter int ROW_W  = 4,
    parameter int COL_W  = 6
) (
    input logic                   vid_sel_n,
    input logic [CPU_AW-1:0]      cpu_addr,
    input logic                   cpu_wr_n,
    input logic                   cpu_rd_n,
    input logic [ROW_W-1:0]       scan_row,
    input logic [COL_W-1:0]       scan_col,
    input logic [ROW_W+COL_W-1:0] vram_addr,
    input logic                   vram_we_n,
    input logic                   vram_rd_n,
    input logic                   scan_snatched
);
    localparam int RAM_AW = ROW_W + COL_W;

    logic known;
    assign known = !$isunknown({vid_sel_n, cpu_addr, cpu_wr_n, cpu_rd_n,
                                scan_row, scan_col, vram_addr, vram_we_n,
                                vram_rd_n, scan_snatched});

    always_comb begin
        if (known) begin
            // R1
            cpu_addr_chk: assert (vid_sel_n || vram_addr == cpu_addr[RAM_AW-1:0]);
            // R2
            scan_addr_chk: assert (!vid_sel_n || vram_addr == {scan_row, scan_col});
            // R3
            scan_no_write_chk: assert (!vid_sel_n || vram_we_n);
            // R4
            scan_no_read_chk: assert (!vid_sel_n || vram_rd_n);
            // R5
            cpu_write_pass_chk: assert (vid_sel_n || vram_we_n == cpu_wr_n);
            // R6
            cpu_read_pass_chk: assert (vid_sel_n || vram_rd_n == cpu_rd_n);
            // R7
            snatch_flag_chk: assert (scan_snatched == !vid_sel_n);
        end
    end
endmodule

bind vram_share_arb vram_share_chk #(
    .CPU_AW (CPU_AW),
    .ROW_W  (ROW_W),
    .COL_W  (COL_W)
) u_chk (.*);

// File: tb/tb_vram_share_arb.sv
module tb_vram_share_arb;
    logic        clk = 1'b0;
    logic        vid_sel_n = 1'b1;
    logic [15:0] cpu_addr = '0;
    logic        cpu_wr_n = 1'b1;
    logic        cpu_rd_n = 1'b1;
    logic [3:0]  scan_row = '0;
    logic [5:0]  scan_col = '0;
    logic [9:0]  vram_addr;
    logic        vram_we_n;
    logic        vram_rd_n;
    logic        scan_snatched;

    int n_vec  = 0;
    int n_bad  = 0;
    int cycles = 0;
    bit done   = 1'b0;

    logic [12:0] exp_q[$];
    string       tag_q[$];

    always #2.5 clk = ~clk;   // 200 MHz

    vram_share_arb dut (
        .vid_sel_n     (vid_sel_n),
        .cpu_addr      (cpu_addr),
        .cpu_wr_n      (cpu_wr_n),
        .cpu_rd_n      (cpu_rd_n),
        .scan_row      (scan_row),
        .scan_col      (scan_col),
        .vram_addr     (vram_addr),
        .vram_we_n     (vram_we_n),
        .vram_rd_n     (vram_rd_n),
        .scan_snatched (scan_snatched)
    );

    // Driver: inputs change at negedge, expectation pushed alongside
    task automatic apply(input logic sel, input logic [15:0] a,
                         input logic wr, input logic rd,
                         input logic [3:0] row, input logic [5:0] col,
                         input string tag);
        logic [9:0] ea;
        logic       ew, er, es;
        @(negedge clk);
        vid_sel_n = sel; cpu_addr = a; cpu_wr_n = wr; cpu_rd_n = rd;
        scan_row = row; scan_col = col;
        if (!sel) begin
            ea = 10'(a % 1024); ew = wr; er = rd; es = 1'b1;
        end else begin
            ea = 10'(int'(row) * 64 + int'(col)); ew = 1'b1; er = 1'b1; es = 1'b0;
        end
        exp_q.push_back({ea, ew, er, es});
        tag_q.push_back(tag);
    endtask

    // Monitor: compare half a cycle after each drive, same cycle
    always @(posedge clk) begin
        if (exp_q.size() > 0) begin
            logic [12:0] e;
            logic [12:0] act;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            act = {vram_addr, vram_we_n, vram_rd_n, scan_snatched};
            n_vec++;
            if (act !== e) begin
                n_bad++;
                $display("FAIL %s: got addr=%h we_n=%b rd_n=%b snatched=%b, expected addr=%h we_n=%b rd_n=%b snatched=%b",
                         t, act[12:3], act[2], act[1], act[0], e[12:3], e[2], e[1], e[0]);
            end
        end
    end

    initial begin
        // Idle state: display owns the RAM (R2, R3, R4, R7)
        apply(1'b1, 16'h0000, 1'b1, 1'b1, 4'd0,  6'd0,  "R2 idle");
        // Display address corners and mixes (R2)
        apply(1'b1, 16'h0000, 1'b1, 1'b1, 4'd15, 6'd63, "R2 last cell");
        apply(1'b1, 16'h0000, 1'b1, 1'b1, 4'd1,  6'd0,  "R2 row weight");
        apply(1'b1, 16'h0000, 1'b1, 1'b1, 4'd0,  6'd1,  "R2 col weight");
        apply(1'b1, 16'h0000, 1'b1, 1'b1, 4'd10, 6'd37, "R2 mixed");
        // CPU strobes ignored while display owns (R3, R4)
        apply(1'b1, 16'h3C55, 1'b0, 1'b1, 4'd4,  6'd18, "R3 wr ignored");
        apply(1'b1, 16'h3C55, 1'b1, 1'b0, 4'd4,  6'd18, "R4 rd ignored");
        apply(1'b1, 16'hFFFF, 1'b0, 1'b0, 4'd9,  6'd2,  "R3 R4 both ignored");
        // CPU write (R1, R5, R7)
        apply(1'b0, 16'h3C2A, 1'b0, 1'b1, 4'd7,  6'd7,  "R5 cpu write");
        apply(1'b0, 16'h03FF, 1'b0, 1'b1, 4'd7,  6'd7,  "R1 cpu top addr");
        // CPU read (R6)
        apply(1'b0, 16'h3C81, 1'b1, 1'b0, 4'd3,  6'd3,  "R6 cpu read");
        // CPU select with no strobe (R7)
        apply(1'b0, 16'h0155, 1'b1, 1'b1, 4'd3,  6'd3,  "R7 select only");
        // Upper CPU bits ignored (R8)
        apply(1'b0, 16'h0000, 1'b1, 1'b0, 4'd0,  6'd0,  "R8 base");
        apply(1'b0, 16'hFC00, 1'b1, 1'b0, 4'd0,  6'd0,  "R8 upper set");
        apply(1'b0, 16'hA800, 1'b0, 1'b1, 4'd15, 6'd63, "R8 upper pattern");
        // Back-to-back ownership flips (R9)
        apply(1'b1, 16'h0123, 1'b0, 1'b0, 4'd12, 6'd33, "R9 to display");
        apply(1'b0, 16'h0123, 1'b0, 1'b1, 4'd12, 6'd33, "R9 to cpu");
        apply(1'b1, 16'h0123, 1'b0, 1'b1, 4'd12, 6'd33, "R9 back to display");
        apply(1'b0, 16'h02AA, 1'b1, 1'b0, 4'd5,  6'd21, "R9 read again");
        // Sweep every row with an alternating column (R2)
        for (int r = 0; r < 16; r++)
            apply(1'b1, 16'hFFFF, 1'b0, 1'b0, 4'(r), 6'(r * 4 + 3), "R2 row sweep");
        // Sweep low CPU bits one at a time (R1)
        for (int b = 0; b < 10; b++)
            apply(1'b0, 16'(1 << b), 1'b1, 1'b1, 4'd0, 6'd0, "R1 bit walk");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
    end

    initial begin
        while (!done && cycles < 5000) begin
            @(posedge clk);
            cycles++;
        end
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout, expected completion");
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule